// File: doc/BRIEF.md
# Egress DSCP Rewrite Selector

This unit sits in the egress path of a switch port and decides which DSCP value is written into the IP header of each outgoing frame. For every frame it receives the DSCP the frame already carries, the QoS class and drop-precedence level assigned at ingress, and the number of the egress port. It looks up a classified DSCP in a programmable table indexed by the drop-precedence and QoS-class pair. It then emits either that classified value or the frame's own DSCP, together with a valid strobe, one cycle later.

Each port keeps two flags: whether it trusts DSCP, and whether a rewrite mapping set is active for it. The classified value is used only when both flags are set for the frame's port. In every other case the frame's DSCP passes through unchanged. The table is loaded through an address/data/write-enable port. The per-port flags are set through a second write port. Header parsing, checksum update and ingress classification belong to other blocks.

Top module: `dscp_rewrite`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0. Reset clears every table entry to 0, sets every port's trust flag to 1 and clears every port's mapping-active flag to 0, so frames pass through until a port's mappings are activated.
- R2: The classified DSCP for a frame is the table entry at index 8 × drop-precedence + QoS class. On the write port this means `tbl_addr[4:3]` selects the drop precedence and `tbl_addr[2:0]` selects the QoS class.
- R3: When the frame's port has both its trust flag and its mapping-active flag set, `out_dscp` equals the classified DSCP.
- R4: When either flag of the frame's port is 0, `out_dscp` equals `in_frame_dscp` of that frame.
- R5: `out_valid` is 1 exactly one cycle after `in_valid` is 1, and 0 one cycle after `in_valid` is 0. Every accepted frame produces exactly one result, in order.
- R6: A lookup in the same cycle as a table write to the same entry returns the old entry. Lookups from the next cycle on return the new value.
- R7: A flag write (`cfg_we`) changes only the port given by `cfg_port`. A lookup in the same cycle on that port uses the old flags, and later lookups use the new flags.
- R8: While no frame is presented, `out_dscp` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame is presented this cycle |
| in_port | input | PORT_W (3) | Egress port of the frame |
| in_frame_dscp | input | DSCP_W (6) | DSCP carried in the frame |
| in_qos | input | QOS_W (3) | Classified QoS class |
| in_dp | input | DP_W (2) | Classified drop-precedence level |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IDX_W (5) | Table entry: {drop precedence, QoS class} |
| tbl_data | input | DSCP_W (6) | DSCP value to store |
| cfg_we | input | 1 | Port flag write enable |
| cfg_port | input | PORT_W (3) | Port whose flags are written |
| cfg_trust | input | 1 | New DSCP trust flag |
| cfg_active | input | 1 | New mapping-active flag |
| out_valid | output | 1 | Result strobe |
| out_dscp | output | DSCP_W (6) | DSCP to write into the frame |

## Verification
On every cycle the assertions check the one-cycle valid relationship and the hold of `out_dscp` while idle. They also check that each result matches the source selected by the port flags: the table entry read out when both flags are set, and the frame's own DSCP otherwise. The assertions cannot show whether the table was indexed in the right order, whether writes landed at the right entry or port, or the read-before-write behaviour. The bench's scenarios cover these. They sweep all 32 index pairs against a known table pattern, combine a write with a lookup of the same entry or port in one cycle, and confirm that a flag write leaves the other ports untouched.

// File: rtl/dscp_rw_pkg.sv
package dscp_rw_pkg;

    parameter int DEF_DSCP_W = 6;
    parameter int DEF_QOS_W  = 3;
    parameter int DEF_DP_W   = 2;
    parameter int DEF_PORTS  = 8;

    // Per-port control flags
    typedef struct packed {
        logic trust;
        logic active;
    } port_flags_t;

endpackage

// File: rtl/dscp_rw_table.sv
// Classified-DSCP lookup table, indexed by {drop precedence, QoS class}.
module dscp_rw_table #(
    parameter int DSCP_W = dscp_rw_pkg::DEF_DSCP_W,
    parameter int QOS_W  = dscp_rw_pkg::DEF_QOS_W,
    parameter int DP_W   = dscp_rw_pkg::DEF_DP_W,
    localparam int IDX_W = QOS_W + DP_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DSCP_W-1:0] wr_data,
    input  logic [QOS_W-1:0]  rd_qos,
    input  logic [DP_W-1:0]   rd_dp,
    output logic [DSCP_W-1:0] rd_data
);

    logic [DSCP_W-1:0] mem_d [DEPTH];
    logic [DSCP_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  rd_idx;

    // dp * 2**QOS_W + qos
    assign rd_idx  = {rd_dp, rd_qos};
    // Read from the registered array: a same-cycle write is not yet visible
    assign rd_data = mem_q[rd_idx];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/dscp_rw_port_cfg.sv
// Per-port trust and mapping-active flags.
module dscp_rw_port_cfg #(
    parameter int NUM_PORTS = dscp_rw_pkg::DEF_PORTS,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam bit FULL     = ((1 << PORT_W) == NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              wr_trust,
    input  logic              wr_active,
    input  logic [PORT_W-1:0] rd_port,
    output logic              rd_trust,
    output logic              rd_active
);

    import dscp_rw_pkg::*;

    port_flags_t flags_d [NUM_PORTS];
    port_flags_t flags_q [NUM_PORTS];
    port_flags_t rd_flags;
    logic        wr_ok;

    generate
        if (FULL) begin : g_full
            assign wr_ok    = 1'b1;
            assign rd_flags = flags_q[rd_port];
        end else begin : g_partial
            // Port numbers beyond the last port write nothing and never rewrite
            assign wr_ok    = (int'(wr_port) < NUM_PORTS);
            assign rd_flags = (int'(rd_port) < NUM_PORTS) ? flags_q[rd_port]
                                                          : '{trust: 1'b0, active: 1'b0};
        end
    endgenerate

    assign rd_trust  = rd_flags.trust;
    assign rd_active = rd_flags.active;

    always_comb begin
        flags_d = flags_q;
        if (wr_en && wr_ok) begin
            flags_d[wr_port] = '{trust: wr_trust, active: wr_active};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                flags_q[i] <= '{trust: 1'b1, active: 1'b0};
            end
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/dscp_rewrite.sv
// Egress DSCP rewrite selector: top level.
module dscp_rewrite #(
    parameter int NUM_PORTS = dscp_rw_pkg::DEF_PORTS,
    parameter int DSCP_W    = dscp_rw_pkg::DEF_DSCP_W,
    parameter int QOS_W     = dscp_rw_pkg::DEF_QOS_W,
    parameter int DP_W      = dscp_rw_pkg::DEF_DP_W,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int IDX_W    = QOS_W + DP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_port,
    input  logic [DSCP_W-1:0] in_frame_dscp,
    input  logic [QOS_W-1:0]  in_qos,
    input  logic [DP_W-1:0]   in_dp,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [DSCP_W-1:0] tbl_data,
    input  logic              cfg_we,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic              cfg_trust,
    input  logic              cfg_active,
    output logic              out_valid,
    output logic [DSCP_W-1:0] out_dscp
);

    typedef struct packed {
        logic              valid;
        logic [DSCP_W-1:0] dscp;
    } out_st_t;

    out_st_t           res_d, res_q;
    logic [DSCP_W-1:0] lk_cls_dscp;
    logic              lk_trust;
    logic              lk_active;

    dscp_rw_table #(
        .DSCP_W (DSCP_W),
        .QOS_W  (QOS_W),
        .DP_W   (DP_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .rd_qos  (in_qos),
        .rd_dp   (in_dp),
        .rd_data (lk_cls_dscp)
    );

    dscp_rw_port_cfg #(
        .NUM_PORTS (NUM_PORTS)
    ) u_port_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_port   (cfg_port),
        .wr_trust  (cfg_trust),
        .wr_active (cfg_active),
        .rd_port   (in_port),
        .rd_trust  (lk_trust),
        .rd_active (lk_active)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.dscp = (lk_trust && lk_active) ? lk_cls_dscp : in_frame_dscp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_dscp  = res_q.dscp;

endmodule

// File: rtl/dscp_rewrite_chk.sv
// Property checker attached to the rewrite selector.
module dscp_rewrite_chk #(
    parameter int DSCP_W = dscp_rw_pkg::DEF_DSCP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DSCP_W-1:0] in_frame_dscp,
    input logic              lk_trust,
    input logic              lk_active,
    input logic [DSCP_W-1:0] lk_cls_dscp,
    input logic              out_valid,
    input logic [DSCP_W-1:0] out_dscp
);

    // R1: no result is produced in the cycle after reset is seen asserted
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R5: a presented frame yields a result one cycle later
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5: no frame, no result
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: both flags set selects the table entry read for that frame
    a_r3_classified: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lk_trust && lk_active) |=> (out_dscp == $past(lk_cls_dscp)));

    // R4: otherwise the frame's own DSCP passes through
    a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(lk_trust && lk_active)) |=> (out_dscp == $past(in_frame_dscp)));

    // R8: idle cycles keep the last result
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_dscp));

endmodule

bind dscp_rewrite dscp_rewrite_chk #(
    .DSCP_W (DSCP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_frame_dscp (in_frame_dscp),
    .lk_trust      (lk_trust),
    .lk_active     (lk_active),
    .lk_cls_dscp   (lk_cls_dscp),
    .out_valid     (out_valid),
    .out_dscp      (out_dscp)
);

// File: tb/test_dscp_rewrite.sv
`timescale 1ns/1ps
module test_dscp_rewrite;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_port = '0;
    logic [5:0] in_frame_dscp = '0;
    logic [2:0] in_qos = '0;
    logic [1:0] in_dp = '0;
    logic       tbl_we = 1'b0;
    logic [4:0] tbl_addr = '0;
    logic [5:0] tbl_data = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_port = '0;
    logic       cfg_trust = 1'b0;
    logic       cfg_active = 1'b0;
    logic       out_valid;
    logic [5:0] out_dscp;

    always #5 clk = ~clk;

    dscp_rewrite i_dscp_rewrite (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_port (in_port), .in_frame_dscp (in_frame_dscp),
        .in_qos (in_qos), .in_dp (in_dp),
        .tbl_we (tbl_we), .tbl_addr (tbl_addr), .tbl_data (tbl_data),
        .cfg_we (cfg_we), .cfg_port (cfg_port), .cfg_trust (cfg_trust), .cfg_active (cfg_active),
        .out_valid (out_valid), .out_dscp (out_dscp)
    );

    // Independent reference state built from the requirements
    logic [5:0] m_tbl    [32];
    bit         m_trust  [8];
    bit         m_active [8];

    typedef struct {
        logic [5:0] dscp;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; expected result computed from the model before updates (R6, R7)
    task automatic step(input bit v, input int p, input int fd, input int q, input int d,
                        input bit tw, input int ta, input int td,
                        input bit cw, input int cp, input bit ct, input bit ca,
                        input string req);
        exp_t e;
        int   idx;
        @(negedge clk);
        in_valid = v; in_port = 3'(p); in_frame_dscp = 6'(fd);
        in_qos = 3'(q); in_dp = 2'(d);
        tbl_we = tw; tbl_addr = 5'(ta); tbl_data = 6'(td);
        cfg_we = cw; cfg_port = 3'(cp); cfg_trust = ct; cfg_active = ca;
        if (v) begin
            idx    = d * 8 + q;
            e.dscp = (m_trust[p] && m_active[p]) ? m_tbl[idx] : 6'(fd);
            e.req  = req;
            sb_q.push_back(e);
        end
        if (tw) m_tbl[ta] = 6'(td);
        if (cw) begin
            m_trust[cp]  = ct;
            m_active[cp] = ca;
        end
    endtask

    task automatic frame(input int p, input int fd, input int q, input int d, input string req);
        step(1'b1, p, fd, q, d, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, req);
    endtask

    task automatic twrite(input int a, input int dat);
        step(1'b0, 0, 0, 0, 0, 1'b1, a, dat, 1'b0, 0, 1'b0, 1'b0, "");
    endtask

    task automatic pcfg(input int p, input bit t, input bit a);
        step(1'b0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b1, p, t, a, "");
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, "");
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5 unexpected result", int'(out_dscp), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_dscp == e.dscp, e.req, int'(out_dscp), int'(e.dscp));
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_tbl[i] = '0;
        for (int i = 0; i < 8; i++) begin
            m_trust[i]  = 1'b1;
            m_active[i] = 1'b0;
        end

        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // R1/R4: default flags pass every port's frame DSCP through
        for (int p = 0; p < 8; p++) frame(p, 63 - p * 5, p, p % 4, "R1 R4 default passthrough");

        // R1: table cleared - activate port 2 and read all entries
        pcfg(2, 1'b1, 1'b1);
        for (int d = 0; d < 4; d++)
            for (int q = 0; q < 8; q++) frame(2, 40, q, d, "R1 cleared table entry");

        // R2: load a distinct pattern, then sweep every {dp, qos}
        for (int a = 0; a < 32; a++) twrite(a, (a * 7 + 5) % 64);
        for (int d = 0; d < 4; d++)
            for (int q = 0; q < 8; q++) frame(2, 1, q, d, "R2 R3 table index 8*dp+qos");

        // R4: each flag combination other than both-set passes through
        pcfg(3, 1'b0, 1'b1);
        pcfg(4, 1'b0, 1'b0);
        pcfg(5, 1'b1, 1'b0);
        frame(3, 11, 7, 3, "R4 untrusted but active");
        frame(4, 12, 2, 1, "R4 untrusted inactive");
        frame(5, 13, 5, 2, "R4 trusted inactive");
        frame(2, 14, 5, 2, "R3 trusted active");

        // R7: flag write with same-cycle lookup on that port sees old flags
        step(1'b1, 6, 21, 3, 1, 1'b0, 0, 0, 1'b1, 6, 1'b1, 1'b1, "R7 same-cycle flag write old");
        frame(6, 21, 3, 1, "R7 new flags next cycle");
        frame(7, 22, 3, 1, "R7 other port untouched");
        frame(5, 23, 3, 1, "R7 other port untouched");

        // R6: table write with same-cycle lookup of that entry sees old value
        step(1'b1, 2, 9, 4, 2, 1'b1, 2 * 8 + 4, 50, 1'b0, 0, 1'b0, 1'b0, "R6 same-cycle table write old");
        frame(2, 9, 4, 2, "R6 new entry next cycle");
        frame(2, 9, 4, 1, "R6 neighbour entry unchanged");

        // R5: back-to-back frames alternating rewrite and passthrough
        for (int k = 0; k < 12; k++)
            frame((k % 2 == 0) ? 2 : 4, k * 3, k % 8, (k / 3) % 4, "R5 back-to-back order");

        // R8: hold after the last frame
        frame(6, 0, 6, 3, "R8 last frame");
        idle();
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R5 idle no result", int'(out_valid), 0);
            check(out_dscp == m_tbl[3 * 8 + 6], "R8 hold while idle", int'(out_dscp), int'(m_tbl[3 * 8 + 6]));
        end

        check(sb_q.size() == 0, "R5 all results delivered", sb_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule